// File: doc/BRIEF.md
# EDO DRAM Random-Access Sequencer

This block drives the row strobe, column strobe, multiplexed address and write controls for single random accesses to an EDO DRAM. A client presents a row, a column, a read/write flag and, for writes, a data word. The request is taken on a rising clock edge while `req_ready` is high. The block then plays out one access on a timeline counted in half memory-clock steps, called half-slots. Slot 0 is the first half of the clock that follows the accepting edge. Slot 1 is the half that follows the next falling edge, and the count goes on from there. Strobe edges can therefore sit on either clock edge. Each strobe output comes from a pair of flops, one clocked on each edge.

Three configuration inputs are sampled only at acceptance. The first sets the minimum spacing between row strobes. The second sets the row-address setup and the row-strobe precharge profile. The third, a single bit, shortens the row-to-column delay for the profiles that allow it. For reads, the word on the DRAM data bus is registered on the rising edge that ends the column-strobe pulse. A one-clock `rd_valid` pulse then presents that word. For writes, the write enable and data-bus drive are held for the whole access.

Top module: `edo_rd_seq`

## Requirements
- R1: While reset is high and in the clock after it, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are 1, `dram_dq_oe` and `rd_valid` are 0, and `req_ready` is 1.
- R2: `dram_ras_n` falls at half-slot S and the row address is on `dram_addr` from slot 0. S is 5, 4 or 3 for `cfg_ras` codes 00, 01 and 10. Code 11 behaves as 00.
- R3: `dram_cas_n` is low for exactly one half-slot, at slot S+D. For `cfg_ras` 00, 10 and 11, D is 4 half-slots when `cfg_fast_rcd` is 0 and 2 when it is 1. For `cfg_ras` 01, D is 3 half-slots whatever the bit.
- R4: `dram_addr` carries the column address for half-slots S+D-1 through S+D+1. It carries the row address for every other half-slot of the access.
- R5: `dram_ras_n` rises at half-slot S+D+2, one full clock after the column strobe falls.
- R6: `req_ready` goes low in the clock after acceptance. It returns high only in the final clock of the access. The access lasts ceil((S + max(Y, D+2+P))/2) clocks. Y is 10, 8 or 6 half-slots for `cfg_cycle` codes 00, 01 and 10, with 11 behaving as 00. P is 4, 3 or 2 half-slots for `cfg_ras` 00, 01 and 10, with 11 behaving as 00. Both strobes are high whenever `req_ready` is high.
- R7: For a read, `rd_valid` is high for exactly one clock, the clock with index (S+D+1)/2 counted from 0 after acceptance. `rd_data` then holds the word present on `dram_dq_in` during the column-strobe low half-slot.
- R8: For a write, `dram_we_n` is 0, `dram_dq_oe` is 1 and `dram_dq_out` holds the accepted data in every clock of the access, and `rd_valid` stays 0. Outside write accesses, `dram_we_n` is 1 and `dram_dq_oe` is 0.
- R9: Changes to `cfg_cycle`, `cfg_ras` or `cfg_fast_rcd` after acceptance have no effect on the access in progress.
- R10: `req_valid` raised while `req_ready` is low is not accepted. The access in progress, its address and its length stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock; both edges are used |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_we | input | 1 | 1 = write access, 0 = read access |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_wdata | input | DATA_W | Write data |
| cfg_cycle | input | 2 | Minimum row-strobe spacing code |
| cfg_ras | input | 2 | Row setup / precharge profile code |
| cfg_fast_rcd | input | 1 | Short row-to-column delay select |
| req_ready | output | 1 | Request will be accepted on the next rising edge |
| rd_valid | output | 1 | One-clock pulse with read data |
| rd_data | output | DATA_W | Captured read word |
| dram_addr | output | ADDR_W | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | DATA_W | Write data to the DRAM bus |
| dram_dq_oe | output | 1 | Drive enable for the DRAM data bus |
| dram_dq_in | input | DATA_W | Data from the DRAM bus |

## Verification
The bench walks every combination of the three configuration fields, reserved codes included, once as a read and once as a write. This separates the profiles that share a setup but differ in delay or spacing: for example, 00 with and without the fast bit, and 00 against 01 cycle codes at equal precharge. Requests arrive with random gaps, and some arrive in the very clock where ready returns. The back-to-back cases show whether the ready window is one clock early or late. During every busy stretch the configuration inputs and the request lines are scrambled with `req_valid` pulsing. A design that resamples configuration or takes a request early then shows a strobe, address or ready mismatch in some half-slot. The data bus carries the real word only around the column pulse, so a capture on the wrong edge returns the filler value.

// File: rtl/edo_seq_pkg.sv
package edo_seq_pkg;

    // Half-clock step counter width and derived clock-phase width
    localparam int HS_W  = 5;
    localparam int PH_W  = HS_W - 1;
    localparam int NSTRB = 3;

    // Bit positions of the strobe vector (ras, cas, column select)
    localparam int STRB_RAS = 0;
    localparam int STRB_CAS = 1;
    localparam int STRB_COL = 2;

    // Pins driven low when asserted: row and column strobes
    localparam logic [NSTRB-1:0] ACT_LOW = 3'b011;

    typedef logic [HS_W-1:0] hslot_t;
    typedef logic [PH_W-1:0] phase_t;

    typedef enum logic [1:0] {
        RP_SLOW = 2'b00,
        RP_MID  = 2'b01,
        RP_FAST = 2'b10,
        RP_RSVD = 2'b11
    } ras_prof_e;

    typedef enum logic [1:0] {
        CY_LONG  = 2'b00,
        CY_MID   = 2'b01,
        CY_SHORT = 2'b10,
        CY_RSVD  = 2'b11
    } cyc_code_e;

    typedef enum logic {
        SEQ_IDLE,
        SEQ_ACTIVE
    } seq_st_e;

    // All durations in half-clock steps
    typedef struct packed {
        hslot_t setup;   // acceptance to row strobe fall
        hslot_t rcd;     // row strobe fall to column strobe fall
        hslot_t pre;     // row strobe precharge
        hslot_t cyc;     // minimum row-strobe spacing
    } edo_tim_t;

    // Asserted-high strobe levels for one half-slot
    typedef struct packed {
        logic col;
        logic cas;
        logic ras;
    } edo_strb_t;

    function automatic edo_tim_t decode_timing(input logic [1:0] cyc_code,
                                               input logic [1:0] ras_code,
                                               input logic       fast_rcd);
        edo_tim_t t;
        unique case (ras_prof_e'(ras_code))
            RP_MID: begin
                t.setup = HS_W'(4);
                t.pre   = HS_W'(3);
                t.rcd   = HS_W'(3);
            end
            RP_FAST: begin
                t.setup = HS_W'(3);
                t.pre   = HS_W'(2);
                t.rcd   = fast_rcd ? HS_W'(2) : HS_W'(4);
            end
            default: begin
                t.setup = HS_W'(5);
                t.pre   = HS_W'(4);
                t.rcd   = fast_rcd ? HS_W'(2) : HS_W'(4);
            end
        endcase
        unique case (cyc_code_e'(cyc_code))
            CY_MID:   t.cyc = HS_W'(8);
            CY_SHORT: t.cyc = HS_W'(6);
            default:  t.cyc = HS_W'(10);
        endcase
        return t;
    endfunction

    function automatic hslot_t cas_slot(input edo_tim_t t);
        return t.setup + t.rcd;
    endfunction

    function automatic edo_strb_t strobes_at(input edo_tim_t t, input hslot_t s);
        edo_strb_t r;
        hslot_t    c;
        c     = cas_slot(t);
        r.ras = (s >= t.setup) && (s < c + HS_W'(2));
        r.cas = (s == c);
        r.col = (s + HS_W'(1) >= c) && (s <= c + HS_W'(1));
        return r;
    endfunction

    // Number of clocks from acceptance until the next acceptance may happen
    function automatic phase_t busy_clocks(input edo_tim_t t);
        hslot_t act;
        hslot_t span;
        hslot_t tot;
        act  = t.rcd + t.pre + HS_W'(2);
        span = (t.cyc > act) ? t.cyc : act;
        tot  = t.setup + span;
        return PH_W'((tot + HS_W'(1)) >> 1);
    endfunction

    function automatic hslot_t even_slot(input phase_t p);
        return {p, 1'b0};
    endfunction

    function automatic hslot_t odd_slot(input phase_t p);
        return {p, 1'b1};
    endfunction

endpackage

// File: rtl/dual_edge_out.sv
// One output bit whose level can change on either clock edge.
// q = q_p ^ q_n: the rising-edge flop sets the first half, the falling-edge
// flop sets the second half from a value staged at the rising edge.
module dual_edge_out #(
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_rise,
    input  logic d_fall,
    output logic q
);
    logic q_p;
    logic q_n;
    logic fall_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_p       <= RST_VAL;
            fall_hold <= RST_VAL;
        end else begin
            q_p       <= d_rise ^ q_n;
            fall_hold <= d_fall;
        end
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            q_n <= 1'b0;
        end else begin
            q_n <= fall_hold ^ q_p;
        end
    end

    assign q = q_p ^ q_n;
endmodule

// File: rtl/edo_rd_capture.sv
// Registers the DRAM data bus on the rising edge that ends the column pulse.
module edo_rd_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_now,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= cap_now;
            if (cap_now) begin
                rd_data <= dq_in;
            end
        end
    end
endmodule

// File: rtl/edo_seq_ctrl.sv
// Access timeline: phase counter in clocks, strobe levels per half-slot.
module edo_seq_ctrl
    import edo_seq_pkg::*;
#(
    parameter int ROW_W  = 10,
    parameter int COL_W  = 9,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        cfg_cycle,
    input  logic [1:0]        cfg_ras,
    input  logic              cfg_fast_rcd,
    output logic              req_ready,
    output edo_strb_t         strb_rise,
    output edo_strb_t         strb_fall,
    output logic              cap_now,
    output logic              wr_drive,
    output logic [ROW_W-1:0]  row_q,
    output logic [COL_W-1:0]  col_q,
    output logic [DATA_W-1:0] wdata_q
);
    seq_st_e  st_q, st_d;
    phase_t   ph_q, ph_d;
    phase_t   last_ph;
    edo_tim_t tim_q, tim_d;
    logic     wr_q, wr_d;
    logic     accept;

    assign last_ph   = busy_clocks(tim_q) - PH_W'(1);
    assign req_ready = (st_q == SEQ_IDLE) || (ph_q == last_ph);
    assign accept    = req_valid && req_ready;

    always_comb begin
        st_d  = st_q;
        ph_d  = ph_q;
        tim_d = tim_q;
        wr_d  = wr_q;
        if (accept) begin
            st_d  = SEQ_ACTIVE;
            ph_d  = '0;
            tim_d = decode_timing(cfg_cycle, cfg_ras, cfg_fast_rcd);
            wr_d  = req_we;
        end else if (st_q == SEQ_ACTIVE) begin
            if (ph_q == last_ph) begin
                st_d = SEQ_IDLE;
            end else begin
                ph_d = ph_q + PH_W'(1);
            end
        end
    end

    // Strobe levels for the two halves of the clock being entered
    always_comb begin
        if (st_d == SEQ_ACTIVE) begin
            strb_rise = strobes_at(tim_d, even_slot(ph_d));
            strb_fall = strobes_at(tim_d, odd_slot(ph_d));
        end else begin
            strb_rise = '0;
            strb_fall = '0;
        end
    end

    assign cap_now = (st_d == SEQ_ACTIVE) && !wr_d &&
                     (even_slot(ph_d) == cas_slot(tim_d) + HS_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= SEQ_IDLE;
            ph_q     <= '0;
            tim_q    <= decode_timing(2'b00, 2'b00, 1'b0);
            wr_q     <= 1'b0;
            wr_drive <= 1'b0;
            row_q    <= '0;
            col_q    <= '0;
            wdata_q  <= '0;
        end else begin
            st_q     <= st_d;
            ph_q     <= ph_d;
            tim_q    <= tim_d;
            wr_q     <= wr_d;
            wr_drive <= (st_d == SEQ_ACTIVE) && wr_d;
            if (accept) begin
                row_q   <= req_row;
                col_q   <= req_col;
                wdata_q <= req_wdata;
            end
        end
    end
endmodule

// File: rtl/edo_rd_seq.sv
module edo_rd_seq
    import edo_seq_pkg::*;
#(
    parameter int ROW_W  = 10,
    parameter int COL_W  = 9,
    parameter int DATA_W = 16,
    parameter int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        cfg_cycle,
    input  logic [1:0]        cfg_ras,
    input  logic              cfg_fast_rcd,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] dram_addr,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic [DATA_W-1:0] dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DATA_W-1:0] dram_dq_in
);
    edo_strb_t        strb_rise;
    edo_strb_t        strb_fall;
    logic [NSTRB-1:0] rise_v;
    logic [NSTRB-1:0] fall_v;
    logic [NSTRB-1:0] pin_v;
    logic             cap_now;
    logic             wr_drive;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic [DATA_W-1:0] wdata_q;

    edo_seq_ctrl #(
        .ROW_W (ROW_W),
        .COL_W (COL_W),
        .DATA_W(DATA_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_we      (req_we),
        .req_row     (req_row),
        .req_col     (req_col),
        .req_wdata   (req_wdata),
        .cfg_cycle   (cfg_cycle),
        .cfg_ras     (cfg_ras),
        .cfg_fast_rcd(cfg_fast_rcd),
        .req_ready   (req_ready),
        .strb_rise   (strb_rise),
        .strb_fall   (strb_fall),
        .cap_now     (cap_now),
        .wr_drive    (wr_drive),
        .row_q       (row_q),
        .col_q       (col_q),
        .wdata_q     (wdata_q)
    );

    assign rise_v = strb_rise;
    assign fall_v = strb_fall;

    // One half-clock-resolution output cell per strobe, polarity from ACT_LOW
    for (genvar g = 0; g < NSTRB; g++) begin : g_strb
        dual_edge_out #(
            .RST_VAL(ACT_LOW[g])
        ) u_de (
            .clk   (clk),
            .rst   (rst),
            .d_rise(rise_v[g] ^ ACT_LOW[g]),
            .d_fall(fall_v[g] ^ ACT_LOW[g]),
            .q     (pin_v[g])
        );
    end

    assign dram_ras_n = pin_v[STRB_RAS];
    assign dram_cas_n = pin_v[STRB_CAS];
    assign dram_addr  = pin_v[STRB_COL] ? ADDR_W'(col_q) : ADDR_W'(row_q);

    assign dram_we_n   = ~wr_drive;
    assign dram_dq_oe  = wr_drive;
    assign dram_dq_out = wdata_q;

    edo_rd_capture #(
        .DATA_W(DATA_W)
    ) u_cap (
        .clk     (clk),
        .rst     (rst),
        .cap_now (cap_now),
        .dq_in   (dram_dq_in),
        .rd_valid(rd_valid),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/edo_rd_seq_chk.sv
module edo_rd_seq_chk (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic rd_valid,
    input logic dram_ras_n,
    input logic dram_cas_n,
    input logic dram_we_n
);
    AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (rst)
        !dram_cas_n |-> !dram_ras_n); // R5

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready); // R6

    AST_READY_PRECHARGED: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (dram_ras_n && dram_cas_n)); // R6

    AST_RDVALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid); // R7

    AST_RDVALID_NOT_WRITE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> dram_we_n); // R8

    AST_NO_ACCEPT_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && !dram_ras_n) |=> !(req_ready && !dram_ras_n)); // R10
endmodule

bind edo_rd_seq edo_rd_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n),
    .dram_we_n (dram_we_n)
);

// File: tb/sim_edo_rd_seq.sv
module sim_edo_rd_seq;
    localparam int NREQ = 128;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [9:0]  req_row = '0;
    logic [8:0]  req_col = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  cfg_cycle = '0;
    logic [1:0]  cfg_ras = '0;
    logic        cfg_fast_rcd = 1'b0;
    logic        req_ready;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [9:0]  dram_addr;
    logic        dram_ras_n;
    logic        dram_cas_n;
    logic        dram_we_n;
    logic [15:0] dram_dq_out;
    logic        dram_dq_oe;
    logic [15:0] dram_dq_in = 16'hDEAD;

    edo_rd_seq u0 (.*);

    always #10 clk = ~clk;   // 50 MHz

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference model state
    int m_act = 0, ph = 0, m_len = 0;
    int m_s = 0, m_d = 0, m_p = 0, m_y = 0;
    int m_wr = 0, m_row = 0, m_col = 0, m_wd = 0;
    int pend = 0, p_cyc = 0, p_ras = 0, p_fast = 0, p_we = 0, p_row = 0, p_col = 0, p_wd = 0;
    int exp_ready = 1;
    int idx = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int word_of(input int r, input int c);
        return ((r & 'hFF) << 8 | (c & 'hFF)) ^ 'h5A3C;
    endfunction

    task automatic start_access();
        m_s = (p_ras == 1) ? 4 : (p_ras == 2) ? 3 : 5;
        m_p = (p_ras == 1) ? 3 : (p_ras == 2) ? 2 : 4;
        m_d = (p_ras == 1) ? 3 : (p_fast != 0 ? 2 : 4);
        m_y = (p_cyc == 1) ? 8 : (p_cyc == 2) ? 6 : 10;
        m_len = (m_s + ((m_y > m_d + 2 + m_p) ? m_y : (m_d + 2 + m_p)) + 1) / 2;
        m_wr = p_we; m_row = p_row; m_col = p_col; m_wd = p_wd;
        m_act = 1; ph = 0;
    endtask

    task automatic drive_dq(input int s);
        if (m_act != 0 && m_wr == 0 && (s == m_s + m_d || s == m_s + m_d + 1))
            dram_dq_in = 16'(word_of(m_row, m_col));
        else
            dram_dq_in = 16'hDEAD;
    endtask

    task automatic check_slot(input int s);
        int e_ras, e_cas, e_col, e_addr, e_rv, e_wr;
        if (m_act != 0) begin
            e_ras  = (s >= m_s && s < m_s + m_d + 2) ? 0 : 1;
            e_cas  = (s == m_s + m_d) ? 0 : 1;
            e_col  = (s >= m_s + m_d - 1 && s <= m_s + m_d + 1) ? 1 : 0;
            e_addr = (e_col != 0) ? m_col : m_row;
            check(dram_ras_n == 1'(e_ras), (s < m_s + m_d) ? "R2 R9" : "R5 R9",
                  "ras_n", int'(dram_ras_n), e_ras);
            check(dram_cas_n == 1'(e_cas), "R3 R9", "cas_n", int'(dram_cas_n), e_cas);
            check(int'(dram_addr) == e_addr, (e_col != 0) ? "R4 R10" : "R2 R10",
                  "addr", int'(dram_addr), e_addr);
        end else begin
            check(dram_ras_n == 1'b1, "R6", "idle ras_n", int'(dram_ras_n), 1);
            check(dram_cas_n == 1'b1, "R6", "idle cas_n", int'(dram_cas_n), 1);
        end
        e_rv = (m_act != 0 && m_wr == 0 && 2 * ph == m_s + m_d + 1) ? 1 : 0;
        check(rd_valid == 1'(e_rv), "R7", "rd_valid", int'(rd_valid), e_rv);
        if (e_rv != 0)
            check(int'(rd_data) == word_of(m_row, m_col), "R7", "rd_data",
                  int'(rd_data), word_of(m_row, m_col));
        e_wr = (m_act != 0 && m_wr != 0) ? 1 : 0;
        check(dram_we_n == 1'(1 - e_wr), "R8", "we_n", int'(dram_we_n), 1 - e_wr);
        check(dram_dq_oe == 1'(e_wr), "R8", "dq_oe", int'(dram_dq_oe), e_wr);
        if (e_wr != 0)
            check(int'(dram_dq_out) == m_wd, "R8", "dq_out", int'(dram_dq_out), m_wd);
    endtask

    task automatic stimulus();
        int combo;
        if (exp_ready != 0 && idx < NREQ) begin
            combo        = (idx >> 1) & 31;
            cfg_cycle    = 2'(combo);
            cfg_ras      = 2'(combo >> 2);
            cfg_fast_rcd = 1'(combo >> 4);
            req_we       = 1'(idx);
            req_row      = 10'($urandom);
            req_col      = 9'($urandom);
            req_wdata    = 16'($urandom);
            req_valid    = ($urandom % 3) != 0;
            if (req_valid) idx++;
        end else if (exp_ready != 0) begin
            req_valid = 1'b0;
        end else begin
            // Busy: scramble configuration and request lines (R9, R10)
            cfg_cycle    = 2'($urandom);
            cfg_ras      = 2'($urandom);
            cfg_fast_rcd = 1'($urandom);
            req_we       = 1'($urandom);
            req_row      = 10'($urandom);
            req_col      = 9'($urandom);
            req_wdata    = 16'($urandom);
            req_valid    = 1'($urandom);
        end
        pend   = (req_valid && exp_ready != 0) ? 1 : 0;
        p_cyc  = int'(cfg_cycle);
        p_ras  = int'(cfg_ras);
        p_fast = int'(cfg_fast_rcd);
        p_we   = int'(req_we);
        p_row  = int'(req_row);
        p_col  = int'(req_col);
        p_wd   = int'(req_wdata);
    endtask

    initial begin
        int tail;
        repeat (3) @(posedge clk);
        #5;
        // R1: reset levels
        check(dram_ras_n == 1'b1, "R1", "reset ras_n", int'(dram_ras_n), 1);
        check(dram_cas_n == 1'b1, "R1", "reset cas_n", int'(dram_cas_n), 1);
        check(dram_we_n == 1'b1, "R1", "reset we_n", int'(dram_we_n), 1);
        check(dram_dq_oe == 1'b0, "R1", "reset dq_oe", int'(dram_dq_oe), 0);
        check(rd_valid == 1'b0, "R1", "reset rd_valid", int'(rd_valid), 0);
        check(req_ready == 1'b1, "R1", "reset ready", int'(req_ready), 1);
        #10;
        rst = 1'b0;
        tail = 0;
        while (tail < 12) begin
            @(posedge clk);
            #5;
            if (pend != 0) begin
                start_access();
            end else if (m_act != 0) begin
                if (ph == m_len - 1) m_act = 0;
                else ph++;
            end
            exp_ready = (m_act == 0 || ph == m_len - 1) ? 1 : 0;
            drive_dq(2 * ph);
            check_slot(2 * ph);
            #10;
            drive_dq(2 * ph + 1);
            check_slot(2 * ph + 1);
            check(req_ready == 1'(exp_ready), "R6 R10", "ready", int'(req_ready), exp_ready);
            stimulus();
            if (idx >= NREQ && m_act == 0 && pend == 0) tail++;
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R6 watchdog act=%0d exp=%0d", idx, NREQ);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule